// File: doc/BRIEF.md
# Instruction Queue with Loop Replay and Pair Fusion

This block sits between an instruction predecode stage and a four-slot main decoder. In normal operation it is an in-order queue: predecode pushes up to four predecoded instructions per cycle, and the queue hands up to four of them per cycle, oldest first, to the decoder read port.

When a taken backward branch is resolved and its whole loop body is still resident in the queue storage, the block enters loop replay. Predecode is stalled and the body is streamed out of the queue again and again. During replay, adjacent instructions that can be merged leave as one fused slot. This lets more than four instructions per cycle reach the decoder, although the decoder only has four slots. A flush, issued on a mispredict or any redirect, ends replay, discards everything that is queued and returns the block to plain queue operation.

Each predecoded instruction is a 2-bit class in the top bits above an opaque payload. The class encoding is 0 = plain, 1 = flag-setting (including arithmetic), 2 = conditional jump, 3 = no-op.

Top module: `insn_loop_queue`

## Requirements
- R1: After reset, no decode slot is valid, replay is inactive and `wr_ready` is high.
- R2: Outside replay, instructions leave in the order written, up to four per cycle, with lane 0 the oldest. Valid lanes are contiguous from lane 0 and `out_fused` is zero. An instruction written at a clock edge appears on the outputs after the following edge.
- R3: The queue holds at most 24 instructions. `wr_ready` is high only when at least four entries are free and replay is inactive. `wr_cnt` values above 4 count as 4.
- R4: A request with length L is accepted when all of these hold: 1 <= L <= the number of instructions written since the last flush (capped at 24), no written instruction is still unread, and `wr_cnt` is 0 in that cycle. `lp_active` then rises after that edge. The body is the last L instructions written, and replay starts with the oldest of them on the outputs one edge later.
- R5: A request with L = 0, with L larger than the resident count, or with unread entries present is ignored, and `lp_active` stays low.
- R6: During replay all four slots are valid every cycle. The body repeats cyclically, and a new pass may start within the same cycle.
- R7: During replay, a slot fuses an instruction with its immediate successor in the body when the pair is flag-setting (1) followed by conditional jump (2), or when either of the two is a no-op (3). Pairing is greedy from the oldest instruction. A fused slot has its `out_fused` bit set, carries the older instruction on `out_first` and the younger on `out_second`. `out_second` is zero for an unfused slot.
- R8: The last instruction of the body is never fused with the first one. It issues alone.
- R9: While replay is active, `wr_ready` is low and writes are dropped; dropped instructions never appear on the outputs.
- R10: A flush cancels replay, discards unread entries, clears the resident count and makes all slots invalid after the edge. `wr_ready` is high afterwards.
- R11: After a flush, normal in-order queue operation resumes with the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_cnt | input | 3 | Number of instructions pushed this cycle (0..4) |
| wr_data | input | 40 | Four instructions, lane 0 oldest, each {class[1:0], payload[7:0]} |
| wr_ready | output | 1 | Queue accepts a push of four this cycle |
| flush | input | 1 | Redirect: cancel replay and empty the queue |
| lp_req | input | 1 | Taken backward branch resolved; request replay |
| lp_len | input | 5 | Loop body length in instructions, branch included |
| lp_active | output | 1 | Replay in progress |
| out_valid | output | 4 | Decode slot valid |
| out_fused | output | 4 | Decode slot carries a fused pair |
| out_first | output | 40 | Older (or only) instruction per slot |
| out_second | output | 40 | Younger instruction of a fused pair per slot |

## Verification
Replay is swept over every body length from 1 to 24 with four class patterns:
- All-plain bodies show the pure wrap order with no fusion.
- A repeating 0..3 class sequence mixes no-op fusion on either side of an instruction.
- Alternating jump/flag bodies put a fusable flag-then-jump pair across the wrap point for every even length, so R8 is tested directly.
- A scrambled class sequence exercises greedy pairing chains.

Short bodies of length 1 to 3 show several passes per cycle. Length 24 shows that the whole storage is used. The rejection cases cover zero length, a length above the resident count, and unread entries. A dropped push during replay is followed by an empty output cycle after the flush.

// File: rtl/insn_loop_queue_pkg.sv
package insn_loop_queue_pkg;

  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_FLAGS = 2'd1,
    CLS_JCC   = 2'd2,
    CLS_NOP   = 2'd3
  } insn_cls_e;

  // Older instruction a, younger instruction b.
  function automatic logic can_pair(input logic [1:0] a, input logic [1:0] b);
    return (a == CLS_FLAGS && b == CLS_JCC) || a == CLS_NOP || b == CLS_NOP;
  endfunction

endpackage

// File: rtl/iql_store.sv
module iql_store #(
  parameter int DEPTH  = 24,
  parameter int LANES  = 4,
  parameter int INSN_W = 10,
  parameter int PORTS  = 8
) (
  input  logic                          clk,
  input  logic [$clog2(LANES+1)-1:0]    we_n,
  input  logic [$clog2(DEPTH)-1:0]      we_base,
  input  logic [LANES*INSN_W-1:0]       we_data,
  input  logic [PORTS*$clog2(DEPTH)-1:0] rd_addr,
  output logic [PORTS*INSN_W-1:0]       rd_data
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [INSN_W-1:0] mem [DEPTH];

  function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W-1:0] a, input int b);
    int t;
    t = int'(a) + b;
    if (t >= DEPTH) t = t - DEPTH;
    return PTR_W'(t);
  endfunction

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (l < int'(we_n)) mem[wrap(we_base, l)] <= we_data[l*INSN_W +: INSN_W];
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    assign rd_data[p*INSN_W +: INSN_W] = mem[rd_addr[p*PTR_W +: PTR_W]];
  end

endmodule

// File: rtl/iql_slot.sv
module iql_slot #(
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] o_in,
  input  logic [CNT_W-1:0] len,
  input  logic [1:0]       cls_a,
  input  logic [1:0]       cls_b,
  output logic             pair,
  output logic [CNT_W-1:0] o_out
);
  import insn_loop_queue_pkg::*;

  logic [CNT_W:0] nx;

  // The successor must lie inside the body: no pairing across the wrap point.
  assign pair  = (({1'b0, o_in} + 1'b1) < {1'b0, len}) && can_pair(cls_a, cls_b);
  assign nx    = {1'b0, o_in} + (pair ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
  assign o_out = (nx >= {1'b0, len}) ? '0 : nx[CNT_W-1:0];

endmodule

// File: rtl/insn_loop_queue.sv
module insn_loop_queue #(
  parameter int DEPTH = 24,
  parameter int LANES = 4,
  parameter int PAY_W = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [$clog2(LANES+1)-1:0]         wr_cnt,
  input  logic [LANES*(PAY_W+2)-1:0]         wr_data,
  output logic                               wr_ready,
  input  logic                               flush,
  input  logic                               lp_req,
  input  logic [$clog2(DEPTH+1)-1:0]         lp_len,
  output logic                               lp_active,
  output logic [LANES-1:0]                   out_valid,
  output logic [LANES-1:0]                   out_fused,
  output logic [LANES*(PAY_W+2)-1:0]         out_first,
  output logic [LANES*(PAY_W+2)-1:0]         out_second
);
  localparam int INSN_W = PAY_W + 2;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH+1);
  localparam int WC_W   = $clog2(LANES+1);
  localparam int PORTS  = 2 * LANES;

  logic [PTR_W-1:0] wr_ptr, rd_ptr, lp_base;
  logic [CNT_W-1:0] occ, hist, lp_n, lp_pos;
  logic             lp_on;

  logic [WC_W-1:0]  wr_eff, n_wr;
  logic [CNT_W-1:0] n_rd;
  logic [CNT_W:0]   hsum;
  logic             lp_take;

  logic [CNT_W-1:0]  off    [LANES+1];
  logic [PTR_W-1:0]  addr_a [LANES];
  logic [PTR_W-1:0]  addr_b [LANES];
  logic [INSN_W-1:0] da     [LANES];
  logic [INSN_W-1:0] db     [LANES];
  logic [LANES-1:0]  pair;
  logic [LANES-1:0]  nx_valid;

  logic [PORTS*PTR_W-1:0]  rd_addr;
  logic [PORTS*INSN_W-1:0] rd_data;

  function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W-1:0] a, input int b);
    int t;
    t = int'(a) + b;
    if (t >= DEPTH) t = t - DEPTH;
    return PTR_W'(t);
  endfunction

  assign lp_active = lp_on;
  assign wr_ready  = !lp_on && (occ <= CNT_W'(DEPTH - LANES));
  assign wr_eff    = (wr_cnt > WC_W'(LANES)) ? WC_W'(LANES) : wr_cnt;
  assign n_wr      = (wr_ready && !flush) ? wr_eff : '0;
  assign n_rd      = lp_on ? '0 : ((occ > CNT_W'(LANES)) ? CNT_W'(LANES) : occ);
  assign hsum      = {1'b0, hist} + (CNT_W+1)'(n_wr);
  assign lp_take   = lp_req && !lp_on && !flush && (occ == '0) && (wr_cnt == '0) &&
                     (lp_len != '0) && (lp_len <= hist);

  iql_store #(.DEPTH(DEPTH), .LANES(LANES), .INSN_W(INSN_W), .PORTS(PORTS)) u_store (
    .clk     (clk),
    .we_n    (n_wr),
    .we_base (wr_ptr),
    .we_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign off[0] = lp_pos;

  for (genvar s = 0; s < LANES; s++) begin : g_slot
    assign addr_a[s] = lp_on ? wrap(lp_base, int'(off[s])) : wrap(rd_ptr, s);
    assign addr_b[s] = wrap(lp_base, int'(off[s]) + 1);
    assign rd_addr[s*PTR_W +: PTR_W]         = addr_a[s];
    assign rd_addr[(LANES+s)*PTR_W +: PTR_W] = addr_b[s];
    assign da[s] = rd_data[s*INSN_W +: INSN_W];
    assign db[s] = rd_data[(LANES+s)*INSN_W +: INSN_W];
    assign nx_valid[s] = lp_on || (CNT_W'(s) < n_rd);

    iql_slot #(.CNT_W(CNT_W)) u_slot (
      .o_in  (off[s]),
      .len   (lp_n),
      .cls_a (da[s][INSN_W-1 -: 2]),
      .cls_b (db[s][INSN_W-1 -: 2]),
      .pair  (pair[s]),
      .o_out (off[s+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      lp_on      <= 1'b0;
      occ        <= '0;
      hist       <= '0;
      lp_pos     <= '0;
      out_valid  <= '0;
      out_fused  <= '0;
      out_first  <= '0;
      out_second <= '0;
      if (rst) begin
        wr_ptr  <= '0;
        rd_ptr  <= '0;
        lp_base <= '0;
        lp_n    <= '0;
      end else begin
        rd_ptr <= wr_ptr;
      end
    end else begin
      out_valid <= nx_valid;
      out_fused <= lp_on ? pair : '0;
      for (int s = 0; s < LANES; s++) begin
        out_first[s*INSN_W +: INSN_W]  <= da[s];
        out_second[s*INSN_W +: INSN_W] <= (lp_on && pair[s]) ? db[s] : '0;
      end
      wr_ptr <= wrap(wr_ptr, int'(n_wr));
      rd_ptr <= wrap(rd_ptr, int'(n_rd));
      occ    <= occ - n_rd + CNT_W'(n_wr);
      hist   <= (hsum > (CNT_W+1)'(DEPTH)) ? CNT_W'(DEPTH) : hsum[CNT_W-1:0];
      if (lp_take) begin
        lp_on   <= 1'b1;
        lp_base <= wrap(wr_ptr, DEPTH - int'(lp_len));
        lp_n    <= lp_len;
        lp_pos  <= '0;
      end else if (lp_on) begin
        lp_pos <= off[LANES];
      end
    end
  end

endmodule

// File: rtl/insn_loop_queue_chk.sv
module insn_loop_queue_chk #(
  parameter int DEPTH = 24,
  parameter int LANES = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       flush,
  input logic                       wr_ready,
  input logic                       lp_active,
  input logic [LANES-1:0]           out_valid,
  input logic [LANES-1:0]           out_fused,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int CNT_W = $clog2(DEPTH+1);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  assert_contig_valid_R2: assert property (@(posedge clk) disable iff (rst)
    ((LANES'(out_valid + 1'b1)) & out_valid) == '0);

  assert_full_width_R6: assert property (@(posedge clk) disable iff (rst)
    (lp_active && !flush) |=> (out_valid == '1));

  assert_fuse_in_replay_R7: assert property (@(posedge clk) disable iff (rst)
    (out_fused != '0) |-> $past(lp_active));

  assert_fused_is_valid_R7: assert property (@(posedge clk) disable iff (rst)
    (out_fused & ~out_valid) == '0);

  assert_stall_in_loop_R9: assert property (@(posedge clk) disable iff (rst)
    lp_active |-> !wr_ready);

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (out_valid == '0 && !lp_active));

endmodule

bind insn_loop_queue insn_loop_queue_chk #(.DEPTH(DEPTH), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .wr_ready  (wr_ready),
  .lp_active (lp_active),
  .out_valid (out_valid),
  .out_fused (out_fused),
  .occ       (occ)
);

// File: tb/insn_loop_queue_tb.sv
module insn_loop_queue_tb;
  localparam int D  = 24;
  localparam int N  = 4;
  localparam int IW = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [2:0]      wr_cnt = '0;
  logic [N*IW-1:0] wr_data = '0;
  logic            wr_ready;
  logic            flush = 1'b0;
  logic            lp_req = 1'b0;
  logic [4:0]      lp_len = '0;
  logic            lp_active;
  logic [N-1:0]    out_valid, out_fused;
  logic [N*IW-1:0] out_first, out_second;

  int n_chk = 0;
  int n_fail = 0;
  logic [IW-1:0] body [D];

  insn_loop_queue u_dut (
    .clk(clk), .rst(rst), .wr_cnt(wr_cnt), .wr_data(wr_data), .wr_ready(wr_ready),
    .flush(flush), .lp_req(lp_req), .lp_len(lp_len), .lp_active(lp_active),
    .out_valid(out_valid), .out_fused(out_fused), .out_first(out_first),
    .out_second(out_second)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] cls_of(input int p, input int i);
    case (p)
      0:       return 2'd0;
      1:       return 2'(i % 4);
      2:       return (i % 2 == 0) ? 2'd2 : 2'd1;
      default: return 2'((i * 5 + i / 3 + 1) % 4);
    endcase
  endfunction

  function automatic bit fusable(input logic [1:0] a, input logic [1:0] b);
    return (a == 2'd1 && b == 2'd2) || a == 2'd3 || b == 2'd3;
  endfunction

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check(out_valid == '0, "R10 flush clears slots", 64'(out_valid), 0);
    check(lp_active == 1'b0, "R10 flush ends replay", 64'(lp_active), 0);
    check(wr_ready == 1'b1, "R10 ready after flush", 64'(wr_ready), 1);
  endtask

  // Push body[0..L-1] in groups of four and check each group drains in order.
  task automatic push_body(input int L);
    for (int c = 0; c < L; c += 4) begin
      int cnt;
      logic [N*IW-1:0] ef;
      cnt = (L - c < 4) ? (L - c) : 4;
      check(wr_ready == 1'b1, "R3 ready when empty", 64'(wr_ready), 1);
      wr_data = '0;
      ef = '0;
      for (int l = 0; l < cnt; l++) begin
        wr_data[l*IW +: IW] = body[c+l];
        ef[l*IW +: IW] = body[c+l];
      end
      wr_cnt = 3'(cnt);
      @(negedge clk);
      wr_cnt = '0;
      @(negedge clk);
      check(out_valid == N'((1 << cnt) - 1), "R2 R11 valid lanes",
            64'(out_valid), 64'((1 << cnt) - 1));
      check(out_fused == '0, "R2 no fusion in queue mode", 64'(out_fused), 0);
      begin
        logic [N*IW-1:0] mask;
        mask = '0;
        for (int l = 0; l < cnt; l++) mask[l*IW +: IW] = '1;
        check((out_first & mask) == ef, "R2 order", 64'(out_first & mask), 64'(ef));
      end
    end
  endtask

  task automatic replay_check(input int L);
    int pos;
    lp_req = 1'b1;
    lp_len = 5'(L);
    @(negedge clk);
    lp_req = 1'b0;
    check(lp_active == 1'b1, "R4 replay accepted", 64'(lp_active), 1);
    pos = 0;
    for (int cyc = 0; cyc < 3; cyc++) begin
      logic [N-1:0] ef;
      logic [N*IW-1:0] e1, e2;
      @(negedge clk);
      if (cyc == 1) begin
        wr_cnt = 3'd4;
        wr_data = {N{10'h3AA}};
      end else begin
        wr_cnt = '0;
      end
      ef = '0; e1 = '0; e2 = '0;
      for (int s = 0; s < N; s++) begin
        bit f;
        f = (pos + 1 < L) && fusable(body[pos][IW-1 -: 2], body[(pos+1) % D][IW-1 -: 2]);
        e1[s*IW +: IW] = body[pos];
        if (f) begin
          ef[s] = 1'b1;
          e2[s*IW +: IW] = body[pos+1];
          pos = pos + 2;
        end else begin
          pos = pos + 1;
        end
        if (pos >= L) pos = 0;
      end
      check(out_valid == '1, "R6 all slots valid", 64'(out_valid), 64'hF);
      check(out_fused == ef, "R7 R8 fused flags", 64'(out_fused), 64'(ef));
      check(out_first == e1, "R6 R8 first instr", 64'(out_first), 64'(e1));
      check(out_second == e2, "R7 second instr", 64'(out_second), 64'(e2));
      if (cyc == 1) check(wr_ready == 1'b0, "R9 stalled in replay", 64'(wr_ready), 0);
    end
    wr_cnt = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == '0, "R1 reset slots", 64'(out_valid), 0);
    check(lp_active == 1'b0, "R1 reset replay", 64'(lp_active), 0);
    check(wr_ready == 1'b1, "R1 reset ready", 64'(wr_ready), 1);

    // R5: nothing resident yet
    lp_req = 1'b1; lp_len = 5'd1;
    @(negedge clk);
    lp_req = 1'b0;
    check(lp_active == 1'b0, "R5 reject empty history", 64'(lp_active), 0);

    for (int i = 0; i < 3; i++) body[i] = {2'd0, 8'(8'h10 + i)};
    push_body(3);
    lp_req = 1'b1; lp_len = 5'd4;
    @(negedge clk);
    lp_req = 1'b0;
    check(lp_active == 1'b0, "R5 reject too long", 64'(lp_active), 0);
    lp_req = 1'b1; lp_len = 5'd0;
    @(negedge clk);
    lp_req = 1'b0;
    check(lp_active == 1'b0, "R5 reject zero length", 64'(lp_active), 0);

    // R5: unread entries present when the request is seen
    wr_data = {N{10'h055}};
    wr_cnt = 3'd4;
    @(negedge clk);
    wr_cnt = '0;
    lp_req = 1'b1; lp_len = 5'd3;
    @(negedge clk);
    lp_req = 1'b0;
    check(lp_active == 1'b0, "R5 reject with unread", 64'(lp_active), 0);
    @(negedge clk);
    do_flush();

    for (int p = 0; p < 4; p++) begin
      for (int L = 1; L <= D; L++) begin
        for (int i = 0; i < L; i++) body[i] = {cls_of(p, i), 8'(p * 64 + i)};
        push_body(L);
        replay_check(L);
        do_flush();
        @(negedge clk);
        check(out_valid == '0, "R9 dropped push never issues", 64'(out_valid), 0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule